// File: doc/BRIEF.md
# Transmit Descriptor Status Write-back Accumulator

This block sits beside a transmit DMA engine and decides when the status of finished transmit descriptors is written back to the host ring. The transmit path reports one completion event for each descriptor whose packet data has reached the on-chip transmit FIFO. Each event carries the descriptor's ring index and its report-status command bit. The block advances the hardware head pointer for each event it consumes. It also groups descriptors into write-back requests, which a separate memory engine carries out.

A descriptor only triggers write-back when its report-status bit is set. A write-back threshold of zero selects a legacy mode. In that mode each flagged descriptor gets a request for its single status byte. A nonzero threshold selects full-descriptor write-back. Pending descriptors are then gathered until their number reaches the threshold, or until the ring drains. The status byte written back always carries the done bit.

A request never runs across the ring's wrap point. A batch that would wrap is issued as two requests. A request is held until the memory engine acknowledges it. Completions that arrive meanwhile wait in a small queue. When the queue is full, they are stalled through the ready signal. Whenever the head pointer catches up with the software tail, the block pulses a queue-empty interrupt cause.

Top module: `tx_wb_accum`

## Requirements
- R1: With the threshold nonzero and nothing pending, a completion whose report-status bit is clear advances the head and produces no request.
- R2: With the threshold zero, every completion whose report-status bit is set produces one request: start equal to its index, count 1, wb_full low (status byte only). Completions with the bit clear produce none.
- R3: With a nonzero threshold, a completion with report-status set opens a pending batch that starts at its index. Every later completion joins the batch. When the batch size reaches the threshold, a request with wb_full high and that start and count is issued.
- R4: The head pointer advances by exactly one, modulo the ring size, for each completion consumed, and never by more than one per cycle. A request covers only descriptors whose completion has already been consumed.
- R5: When a consumed completion makes the head equal to sw_tail, irq_qempty pulses high for one cycle. Any pending batch is flushed as a full request in the same step.
- R6: No request crosses ring index RING-1 to 0. A batch that would wrap is issued as a request up to the ring end, followed by a second request that starts at index 0 with the remainder.
- R7: A request stays valid, with stable start, count and mode, until wb_ack. Completions offered meanwhile are queued, or stalled by cmp_ready low, and none is lost.
- R8: Every request's wb_status has bit 0 (done) set.
- R9: After reset the head is 0, wb_valid and irq_qempty are low and cmp_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_thresh | input | THR_W | Write-back threshold, 0 selects status-byte legacy mode |
| sw_tail | input | IDX_W | Software tail pointer |
| cmp_valid | input | 1 | Completion event offered |
| cmp_ready | output | 1 | Completion queue can accept |
| cmp_idx | input | IDX_W | Ring index of completed descriptor |
| cmp_rs | input | 1 | Report-status command bit of that descriptor |
| wb_valid | output | 1 | Write-back request valid |
| wb_ack | input | 1 | Memory engine accepts the request |
| wb_start | output | IDX_W | First ring index of the request |
| wb_count | output | THR_W | Number of descriptors in the request |
| wb_full | output | 1 | 1 full descriptors, 0 status byte only |
| wb_status | output | 8 | Status byte to write, done bit at bit 0 |
| hw_head | output | IDX_W | Hardware head pointer |
| irq_qempty | output | 1 | Queue-empty interrupt cause pulse |

## Verification
Every cycle, the assertions check that the head moves by at most one step, that no request wraps or is empty, and that requests stay stable until acknowledged. They also check that legacy requests are single status-byte writes, that full requests never exceed the threshold, and that the interrupt fires only when the head equals the tail. Only the bench's scenarios can show that batches start at the right descriptor and close at the right size, and that flushes on ring drain happen. The same holds for splits at the wrap point appearing in order and for back-pressured completions all being accounted for. For this, the bench sweeps thresholds, report-status patterns, batch lengths and ring positions against an arithmetic model.

// File: rtl/tx_wb_pkg.sv
// Shared constants for the transmit write-back accumulator.
package tx_wb_pkg;
    // Bit of the written status byte that tells software the descriptor is done.
    localparam int STA_DONE_BIT = 0;

    // Write-back mode carried with each request.
    typedef enum logic {
        WB_STATUS_ONLY = 1'b0,
        WB_FULL_DESC   = 1'b1
    } wb_mode_e;
endpackage

// File: rtl/cmp_queue.sv
// Small first-in first-out queue holding completion events.
// Assumes DEPTH is a power of two; push is ignored when full.
module cmp_queue #(
    parameter int W     = 5,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         not_full,
    input  logic         pop,
    output logic         not_empty,
    output logic [W-1:0] pop_data
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW:0]   fill;

    assign not_full  = (fill != (PW+1)'(DEPTH));
    assign not_empty = (fill != '0);
    assign pop_data  = mem[rd_ptr];

    // Store an accepted event.
    always_ff @(posedge clk) begin
        if (push && not_full) mem[wr_ptr] <= push_data;
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push && not_full) wr_ptr <= wr_ptr + 1'b1;
            if (pop && not_empty) rd_ptr <= rd_ptr + 1'b1;
            case ({push && not_full, pop && not_empty})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/wb_batcher.sv
// Consumes completions one at a time, advances the head and decides batches.
// Assumes completions arrive in ring order (index equals current head) and
// that the threshold only changes while nothing is pending.
module wb_batcher
    import tx_wb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thresh,
    input  logic [IDX_W-1:0] tail,
    input  logic             q_valid,
    input  logic [IDX_W-1:0] q_idx,
    input  logic             q_rs,
    output logic             q_pop,
    input  logic             iss_idle,
    output logic             b_valid,
    output logic [IDX_W-1:0] b_start,
    output logic [THR_W-1:0] b_count,
    output wb_mode_e         b_mode,
    output logic [IDX_W-1:0] head,
    output logic             irq
);
    logic [THR_W-1:0] pcnt, cnt_inc;
    logic [IDX_W-1:0] pstart, first, nxt_head;
    logic             legacy, joins, closes;

    // Decide what the event at the queue front does.
    always_comb begin
        q_pop    = q_valid && iss_idle;
        legacy   = (thresh == '0);
        nxt_head = head + 1'b1;
        joins    = !legacy && ((pcnt != '0) || q_rs);
        cnt_inc  = pcnt + 1'b1;
        first    = (pcnt == '0) ? q_idx : pstart;
        closes   = joins && ((cnt_inc >= thresh) || (nxt_head == tail));
        b_valid  = q_pop && (legacy ? q_rs : closes);
        b_start  = legacy ? q_idx : first;
        b_count  = legacy ? THR_W'(1) : cnt_inc;
        b_mode   = legacy ? WB_STATUS_ONLY : WB_FULL_DESC;
    end

    // Update head, pending batch and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            pcnt   <= '0;
            pstart <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (q_pop) begin
                head <= nxt_head;
                irq  <= (nxt_head == tail);
                if (joins) begin
                    pcnt   <= closes ? '0 : cnt_inc;
                    pstart <= first;
                end
            end
        end
    end
endmodule

// File: rtl/wb_issuer.sv
// Holds one write-back request until acknowledged; splits batches at the
// ring wrap point into two consecutive requests.
module wb_issuer
    import tx_wb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             b_valid,
    input  logic [IDX_W-1:0] b_start,
    input  logic [THR_W-1:0] b_count,
    input  wb_mode_e         b_mode,
    output logic             idle,
    output logic             wb_valid,
    input  logic             wb_ack,
    output logic [IDX_W-1:0] wb_start,
    output logic [THR_W-1:0] wb_count,
    output wb_mode_e         wb_mode
);
    localparam int RING = 1 << IDX_W;
    localparam int AW   = ((IDX_W > THR_W) ? IDX_W : THR_W) + 1;

    logic [AW-1:0]    room, want;
    logic [THR_W-1:0] rem;

    // Space left before the ring end, and the size asked for.
    always_comb begin
        room = AW'(RING) - AW'(b_start);
        want = AW'(b_count);
        idle = !wb_valid;
    end

    // Load, split and retire requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_start <= '0;
            wb_count <= '0;
            wb_mode  <= WB_STATUS_ONLY;
            rem      <= '0;
        end else if (!wb_valid) begin
            if (b_valid) begin
                wb_valid <= 1'b1;
                wb_start <= b_start;
                wb_mode  <= b_mode;
                if (want > room) begin
                    wb_count <= THR_W'(room);
                    rem      <= THR_W'(want - room);
                end else begin
                    wb_count <= b_count;
                    rem      <= '0;
                end
            end
        end else if (wb_ack) begin
            if (rem != '0) begin
                wb_start <= '0;
                wb_count <= rem;
                rem      <= '0;
            end else begin
                wb_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_wb_accum.sv
// Top of the transmit descriptor status write-back accumulator.
// Queues completion events, advances the head, gathers write-back batches
// and issues them one at a time to a memory engine.
module tx_wb_accum
    import tx_wb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int THR_W = 4,
    parameter int QDEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] wb_thresh,
    input  logic [IDX_W-1:0] sw_tail,
    input  logic             cmp_valid,
    output logic             cmp_ready,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic             cmp_rs,
    output logic             wb_valid,
    input  logic             wb_ack,
    output logic [IDX_W-1:0] wb_start,
    output logic [THR_W-1:0] wb_count,
    output logic             wb_full,
    output logic [7:0]       wb_status,
    output logic [IDX_W-1:0] hw_head,
    output logic             irq_qempty
);
    localparam int QW = IDX_W + 1;

    logic             q_valid, q_pop, iss_idle, b_valid;
    logic [QW-1:0]    q_data;
    logic [IDX_W-1:0] b_start;
    logic [THR_W-1:0] b_count;
    wb_mode_e         b_mode, wb_mode;

    cmp_queue #(.W(QW), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(cmp_valid), .push_data({cmp_rs, cmp_idx}), .not_full(cmp_ready),
        .pop(q_pop), .not_empty(q_valid), .pop_data(q_data)
    );

    wb_batcher #(.IDX_W(IDX_W), .THR_W(THR_W)) u_batch (
        .clk(clk), .rst_n(rst_n), .thresh(wb_thresh), .tail(sw_tail),
        .q_valid(q_valid), .q_idx(q_data[IDX_W-1:0]), .q_rs(q_data[IDX_W]),
        .q_pop(q_pop), .iss_idle(iss_idle),
        .b_valid(b_valid), .b_start(b_start), .b_count(b_count), .b_mode(b_mode),
        .head(hw_head), .irq(irq_qempty)
    );

    wb_issuer #(.IDX_W(IDX_W), .THR_W(THR_W)) u_issue (
        .clk(clk), .rst_n(rst_n),
        .b_valid(b_valid), .b_start(b_start), .b_count(b_count), .b_mode(b_mode),
        .idle(iss_idle), .wb_valid(wb_valid), .wb_ack(wb_ack),
        .wb_start(wb_start), .wb_count(wb_count), .wb_mode(wb_mode)
    );

    // Present mode and the status byte with its done bit.
    always_comb begin
        wb_full   = (wb_mode == WB_FULL_DESC);
        wb_status = 8'(1 << STA_DONE_BIT);
    end
endmodule

// File: rtl/tx_wb_accum_chk.sv
// Cycle-level properties of the write-back accumulator, bound to the top.
module tx_wb_accum_chk #(
    parameter int IDX_W = 4,
    parameter int THR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [THR_W-1:0] wb_thresh,
    input logic [IDX_W-1:0] sw_tail,
    input logic             wb_valid,
    input logic             wb_ack,
    input logic [IDX_W-1:0] wb_start,
    input logic [THR_W-1:0] wb_count,
    input logic             wb_full,
    input logic [IDX_W-1:0] hw_head,
    input logic             irq_qempty
);
    localparam int RING = 1 << IDX_W;
    localparam int AW   = ((IDX_W > THR_W) ? IDX_W : THR_W) + 2;

    // Head moves by at most one step per cycle.
    p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_head != $past(hw_head)) |-> (hw_head == IDX_W'($past(hw_head) + 1'b1)));

    // Requests never cross the wrap point and are never empty.
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ((AW'(wb_start) + AW'(wb_count)) <= AW'(RING)) && (wb_count != '0));

    // Request held stable until acknowledged.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_start)
                                   && $stable(wb_count) && $stable(wb_full)));

    // Legacy requests are single status-byte writes in threshold-zero mode.
    p_legacy_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_full) |-> (wb_count == THR_W'(1)) && (wb_thresh == '0));

    // Full requests never exceed the threshold.
    p_batch_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_full) |-> (wb_count <= wb_thresh) && (wb_thresh != '0));

    // Interrupt cause only when the ring has drained.
    p_qempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_qempty |-> (hw_head == sw_tail));
endmodule

bind tx_wb_accum tx_wb_accum_chk #(.IDX_W(IDX_W), .THR_W(THR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_thresh(wb_thresh), .sw_tail(sw_tail),
    .wb_valid(wb_valid), .wb_ack(wb_ack), .wb_start(wb_start),
    .wb_count(wb_count), .wb_full(wb_full), .hw_head(hw_head),
    .irq_qempty(irq_qempty)
);

// File: tb/tx_wb_accum_tb.sv
// Sweeps thresholds, report-status patterns and batch lengths around the
// ring and compares requests, head and interrupts against a bench model.
module tx_wb_accum_tb;
    localparam int IDX_W = 4;
    localparam int THR_W = 4;
    localparam int RING  = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [THR_W-1:0] wb_thresh = '0;
    logic [IDX_W-1:0] sw_tail = '0;
    logic             cmp_valid = 1'b0;
    logic             cmp_ready;
    logic [IDX_W-1:0] cmp_idx = '0;
    logic             cmp_rs = 1'b0;
    logic             wb_valid;
    logic             wb_ack = 1'b0;
    logic [IDX_W-1:0] wb_start;
    logic [THR_W-1:0] wb_count;
    logic             wb_full;
    logic [7:0]       wb_status;
    logic [IDX_W-1:0] hw_head;
    logic             irq_qempty;

    int errors = 0, checks = 0;
    int n_got = 0, n_exp = 0, irq_cnt = 0;
    bit saw_stall = 0;
    int got_s[64], got_c[64], got_f[64], got_d[64];
    int exp_s[64], exp_c[64], exp_f[64];

    always #4 clk = ~clk;

    tx_wb_accum #(.IDX_W(IDX_W), .THR_W(THR_W), .QDEPTH(4)) u_dut (.*);

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Collect and acknowledge requests after a delay.
    initial begin
        forever begin
            @(negedge clk);
            if (wb_valid && !wb_ack) begin
                if (n_got < 64) begin
                    got_s[n_got] = wb_start;
                    got_c[n_got] = wb_count;
                    got_f[n_got] = wb_full;
                    got_d[n_got] = wb_status[0];
                end
                n_got++;
                repeat (3) @(negedge clk);
                wb_ack = 1'b1;
                @(negedge clk);
                wb_ack = 1'b0;
            end
        end
    end

    // Count interrupt pulses.
    initial begin
        forever begin
            @(negedge clk);
            if (irq_qempty) irq_cnt++;
        end
    end

    task automatic expect_req(input int s, input int c, input int f);
        int room;
        room = RING - s;
        if (c > room) begin
            exp_s[n_exp] = s; exp_c[n_exp] = room; exp_f[n_exp] = f; n_exp++;
            exp_s[n_exp] = 0; exp_c[n_exp] = c - room; exp_f[n_exp] = f; n_exp++;
        end else begin
            exp_s[n_exp] = s; exp_c[n_exp] = c; exp_f[n_exp] = f; n_exp++;
        end
    endtask

    task automatic push(input int idx, input bit rs);
        cmp_idx = IDX_W'(idx);
        cmp_rs = rs;
        cmp_valid = 1'b1;
        while (!cmp_ready) begin
            saw_stall = 1;
            @(negedge clk);
        end
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    task automatic run_scenario(input int thr, input int n, input int pat, inout int mh);
        int pc, st, h, tl;
        pc = 0; st = 0; h = mh;
        tl = (mh + n) % RING;
        n_got = 0; n_exp = 0; irq_cnt = 0;
        wb_thresh = THR_W'(thr);
        sw_tail = IDX_W'(tl);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            bit rs;
            int idx;
            rs = pat[i];
            idx = h;
            h = (h + 1) % RING;
            if (thr == 0) begin
                if (rs) expect_req(idx, 1, 0);
            end else if (pc > 0 || rs) begin
                if (pc == 0) st = idx;
                pc++;
                if (pc >= thr || h == tl) begin
                    expect_req(st, pc, 1);
                    pc = 0;
                end
            end
            push(idx, rs);
        end
        while (hw_head != IDX_W'(tl)) @(negedge clk);
        repeat (40) @(negedge clk);
        mh = tl;
        check(n_got == n_exp,
              $sformatf("R1 R2 R3 R6 request count thr=%0d n=%0d pat=%h", thr, n, pat),
              n_got, n_exp);
        if (n_got == n_exp) begin
            for (int k = 0; k < n_exp; k++) begin
                check(got_s[k] == exp_s[k] && got_c[k] == exp_c[k] && got_f[k] == exp_f[k],
                      $sformatf("R2 R3 R6 request %0d start/count/full thr=%0d (got %0d/%0d/%0d)",
                                k, thr, got_s[k], got_c[k], got_f[k]),
                      got_s[k] * 1000 + got_c[k] * 10 + got_f[k],
                      exp_s[k] * 1000 + exp_c[k] * 10 + exp_f[k]);
                check(got_d[k] == 1, "R8 done bit in status", got_d[k], 1);
            end
        end
        check(int'(hw_head) == tl, "R4 head after batch", hw_head, tl);
        check(irq_cnt == 1, "R5 queue-empty pulse count", irq_cnt, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        int mh;
        int thrs[7] = '{0, 1, 2, 3, 4, 7, 15};
        int lens[4] = '{1, 5, 9, 15};
        int pats[5] = '{'h0000, 'hFFFF, 'h0001, 'h4210, 'h5A5A};
        mh = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hw_head == '0, "R9 head after reset", hw_head, 0);
        check(!wb_valid, "R9 no request after reset", wb_valid, 0);
        check(!irq_qempty, "R9 no interrupt after reset", irq_qempty, 0);
        check(cmp_ready, "R9 ready after reset", cmp_ready, 1);
        foreach (thrs[a])
            foreach (lens[b])
                foreach (pats[c])
                    run_scenario(thrs[a], lens[b], pats[c] & ((1 << lens[b]) - 1), mh);
        check(saw_stall, "R7 queue filled while request outstanding", saw_stall, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule